// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside a processor's control path and decides, every clock, whether an exception must be entered. Seven sources arrive together: system reset, data abort, fast interrupt request, normal interrupt request, prefetch abort, undefined instruction and supervisor call. The block also receives the current program counter and the current status word. The two interrupt requests are level-sensitive and can be masked by bits of the status word. The other five sources are single-cycle event strobes from the pipeline.

When any source is active and not masked, the block picks the winner by fixed priority. It then registers one complete entry packet: a one-cycle take strobe, the vector address, the target mode, the link value, the status word to save, the new status word and a register-bank select code. The register file and the status logic apply this packet in the cycle the strobe is high. When no source is active, the strobe stays low and the packet holds its previous contents.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The vector address is 0x00 for reset, 0x04 for undefined instruction, 0x08 for supervisor call, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. The value 0x14 is never produced.
- R2: When several sources are active, the winner follows this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call. Undefined instruction beats supervisor call when both are active.
- R3: `mode_o` carries the 5-bit target mode. Reset and supervisor call give 10011. Both aborts give 10111. Undefined instruction gives 11011. Normal interrupt gives 10010. Fast interrupt gives 10001.
- R4: Status bit 7 set to 1 blocks the normal interrupt, and status bit 6 set to 1 blocks the fast interrupt. A blocked request has no effect at the ports. A request held high while unblocked is taken again in every cycle.
- R5: On entry, `link_o` equals the sampled PC plus 4, modulo 2^ADDR_W. `saved_status_o` equals the sampled status word.
- R6: `new_status_o` copies the sampled status word with these changes: bits [4:0] take the target mode, bit 7 (interrupt mask) is set, and bit 5 (compressed state) is cleared. Bit 6 (fast mask) is set on reset and fast-interrupt entry and kept otherwise. The flag bits [31:28] are not changed.
- R7: `bank_o` encodes the banked registers to switch in. Code 1 means fast interrupt (R8 to R14). Code 2 means normal interrupt, 3 supervisor, 4 abort and 5 undefined; each of these banks R13 and R14 only.
- R8: Outputs are registered. `take_o` is high in the cycle after the clock edge that sampled an active source. In a cycle with nothing to take, `take_o` is 0 and all other outputs keep their last values.
- R9: While `rst_n` is low, every output is 0. Release of `rst_n` is synchronised to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| src_reset_i | input | 1 | Reset exception request |
| src_undef_i | input | 1 | Undefined instruction event |
| src_svc_i | input | 1 | Supervisor call event |
| src_pabt_i | input | 1 | Prefetch abort event |
| src_dabt_i | input | 1 | Data abort event |
| norm_irq_i | input | 1 | Normal interrupt request, level |
| fast_irq_i | input | 1 | Fast interrupt request, level |
| pc_i | input | ADDR_W | Current program counter |
| status_i | input | 32 | Current status word |
| take_o | output | 1 | Enter exception this cycle |
| vector_o | output | ADDR_W | Vector address |
| mode_o | output | 5 | Target mode code |
| link_o | output | ADDR_W | Value for the banked link register |
| saved_status_o | output | 32 | Value for the saved status register |
| new_status_o | output | 32 | Updated current status word |
| bank_o | output | 3 | Banked register select code |

## Verification
Priority arbitration and interrupt masking are the two functions that fall in the same cycle. A masked interrupt must give way to a lower-priority abort, and an unmasked one must beat it. To provoke this, the bench sweeps every combination of the seven sources against all four settings of the two mask bits. For each vector it computes the expected winner independently, then compares the whole registered packet one cycle later. That comparison includes the hold behaviour in the cycles where masking leaves nothing to take.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_SRC = 7;
  localparam int STAT_W  = 32;
  localparam int MODE_W  = 5;
  localparam int BANK_W  = 3;
  localparam int VOFF_W  = 5;

  // status word bit positions decoded by neighbouring logic
  localparam int ST_MASK_NORM = 7;
  localparam int ST_MASK_FAST = 6;
  localparam int ST_COMPACT   = 5;

  // index order is priority order, 0 highest
  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_DABT  = 3'd1,
    EK_FAST  = 3'd2,
    EK_NORM  = 3'd3,
    EK_PABT  = 3'd4,
    EK_UNDEF = 3'd5,
    EK_SVC   = 3'd6,
    EK_NONE  = 3'd7
  } exc_kind_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_USER  = 5'b10000,
    MODE_FAST  = 5'b10001,
    MODE_NORM  = 5'b10010,
    MODE_SUPV  = 5'b10011,
    MODE_ABORT = 5'b10111,
    MODE_UNDEF = 5'b11011,
    MODE_SYS   = 5'b11111
  } cpu_mode_e;

  typedef enum logic [BANK_W-1:0] {
    BANK_COMMON = 3'd0,
    BANK_FAST   = 3'd1,
    BANK_NORM   = 3'd2,
    BANK_SUPV   = 3'd3,
    BANK_ABORT  = 3'd4,
    BANK_UNDEF  = 3'd5
  } bank_sel_e;

  function automatic logic [VOFF_W-1:0] vec_offset(exc_kind_e k);
    case (k)
      EK_RESET: vec_offset = 5'h00;
      EK_UNDEF: vec_offset = 5'h04;
      EK_SVC:   vec_offset = 5'h08;
      EK_PABT:  vec_offset = 5'h0C;
      EK_DABT:  vec_offset = 5'h10;
      EK_NORM:  vec_offset = 5'h18;
      EK_FAST:  vec_offset = 5'h1C;
      default:  vec_offset = 5'h00;
    endcase
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == 0) begin : g_top
      assign grant[g] = req[g];
    end else begin : g_rest
      assign grant[g] = req[g] & ~(|req[g-1:0]);
    end
  end

  assign any = |req;
endmodule

// File: rtl/exc_kind_enc.sv
module exc_kind_enc
  import exc_entry_pkg::*;
(
  input  logic [NUM_SRC-1:0] grant,
  output exc_kind_e          kind
);
  always_comb begin
    kind = EK_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (grant[i]) kind = exc_kind_e'(3'(i));
    end
  end
endmodule

// File: rtl/exc_target_map.sv
module exc_target_map
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  exc_kind_e          kind,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [STAT_W-1:0]  status,
  output logic [ADDR_W-1:0]  vector,
  output logic [MODE_W-1:0]  mode,
  output logic [BANK_W-1:0]  bank,
  output logic [ADDR_W-1:0]  link,
  output logic [STAT_W-1:0]  new_status
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(4);

  cpu_mode_e mode_c;
  bank_sel_e bank_c;
  logic      set_fast_mask;

  always_comb begin
    mode_c        = MODE_SUPV;
    bank_c        = BANK_SUPV;
    set_fast_mask = 1'b0;
    case (kind)
      EK_RESET: begin
        mode_c        = MODE_SUPV;
        bank_c        = BANK_SUPV;
        set_fast_mask = 1'b1;
      end
      EK_SVC: begin
        mode_c = MODE_SUPV;
        bank_c = BANK_SUPV;
      end
      EK_DABT, EK_PABT: begin
        mode_c = MODE_ABORT;
        bank_c = BANK_ABORT;
      end
      EK_UNDEF: begin
        mode_c = MODE_UNDEF;
        bank_c = BANK_UNDEF;
      end
      EK_NORM: begin
        mode_c = MODE_NORM;
        bank_c = BANK_NORM;
      end
      EK_FAST: begin
        mode_c        = MODE_FAST;
        bank_c        = BANK_FAST;
        set_fast_mask = 1'b1;
      end
      default: begin
        mode_c = MODE_SUPV;
        bank_c = BANK_SUPV;
      end
    endcase
  end

  always_comb begin
    new_status                 = status;
    new_status[MODE_W-1:0]     = mode_c;
    new_status[ST_MASK_NORM]   = 1'b1;
    new_status[ST_COMPACT]     = 1'b0;
    if (set_fast_mask) new_status[ST_MASK_FAST] = 1'b1;
  end

  assign vector = {{(ADDR_W-VOFF_W){1'b0}}, vec_offset(kind)};
  assign mode   = mode_c;
  assign bank   = bank_c;
  assign link   = pc + PC_STEP;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_reset_i,
  input  logic               src_undef_i,
  input  logic               src_svc_i,
  input  logic               src_pabt_i,
  input  logic               src_dabt_i,
  input  logic               norm_irq_i,
  input  logic               fast_irq_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [31:0]        status_i,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vector_o,
  output logic [4:0]         mode_o,
  output logic [ADDR_W-1:0]  link_o,
  output logic [31:0]        saved_status_o,
  output logic [31:0]        new_status_o,
  output logic [2:0]         bank_o
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic               any_req;
  exc_kind_e          kind;

  logic [ADDR_W-1:0]  vec_d, link_d;
  logic [MODE_W-1:0]  mode_d;
  logic [BANK_W-1:0]  bank_d;
  logic [STAT_W-1:0]  nstat_d;

  logic               take_q;
  logic [ADDR_W-1:0]  vec_q, link_q;
  logic [MODE_W-1:0]  mode_q;
  logic [BANK_W-1:0]  bank_q;
  logic [STAT_W-1:0]  nstat_q, sstat_q;
  logic               load_en;

  exc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // request vector laid out in priority order
  always_comb begin
    req            = '0;
    req[EK_RESET]  = src_reset_i;
    req[EK_DABT]   = src_dabt_i;
    req[EK_FAST]   = fast_irq_i & ~status_i[ST_MASK_FAST];
    req[EK_NORM]   = norm_irq_i & ~status_i[ST_MASK_NORM];
    req[EK_PABT]   = src_pabt_i;
    req[EK_UNDEF]  = src_undef_i;
    req[EK_SVC]    = src_svc_i;
  end

  exc_prio_sel #(.N(NUM_SRC)) u_prio (
    .req   (req),
    .grant (grant),
    .any   (any_req)
  );

  exc_kind_enc u_enc (
    .grant (grant),
    .kind  (kind)
  );

  exc_target_map #(.ADDR_W(ADDR_W)) u_map (
    .kind       (kind),
    .pc         (pc_i),
    .status     (status_i),
    .vector     (vec_d),
    .mode       (mode_d),
    .bank       (bank_d),
    .link       (link_d),
    .new_status (nstat_d)
  );

  assign load_en = any_req;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) take_q <= 1'b0;
    else             take_q <= any_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q   <= '0;
      link_q  <= '0;
      mode_q  <= '0;
      bank_q  <= '0;
      nstat_q <= '0;
      sstat_q <= '0;
    end else if (load_en) begin
      vec_q   <= vec_d;
      link_q  <= link_d;
      mode_q  <= mode_d;
      bank_q  <= bank_d;
      nstat_q <= nstat_d;
      sstat_q <= status_i;
    end
  end

  assign take_o         = take_q;
  assign vector_o       = vec_q;
  assign mode_o         = mode_q;
  assign link_o         = link_q;
  assign saved_status_o = sstat_q;
  assign new_status_o   = nstat_q;
  assign bank_o         = bank_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_reset_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [31:0]       status_i,
  input logic              take_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [4:0]        mode_o,
  input logic [ADDR_W-1:0] link_o,
  input logic [31:0]       saved_status_o,
  input logic [31:0]       new_status_o,
  input logic [2:0]        bank_o
);
  assert_vec_hole_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vector_o != ADDR_W'(32'h14));

  assert_reset_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_reset_i) && $past(rst_n) && take_o) |-> (vector_o == '0 && mode_o == 5'b10011));

  assert_fast_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && mode_o == 5'b10001) |-> !$past(status_i[6]));

  assert_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> link_o == $past(pc_i) + ADDR_W'(4));

  assert_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> saved_status_o == $past(status_i));

  assert_entry_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (new_status_o[7] && !new_status_o[5] && new_status_o[4:0] == mode_o
                && new_status_o[31:28] == saved_status_o[31:28]));

  assert_fast_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((mode_o == 5'b10001) == (bank_o == 3'd1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> ($stable(vector_o) && $stable(link_o) && $stable(new_status_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .src_reset_i    (src_reset_i),
  .pc_i           (pc_i),
  .status_i       (status_i),
  .take_o         (take_o),
  .vector_o       (vector_o),
  .mode_o         (mode_o),
  .link_o         (link_o),
  .saved_status_o (saved_status_o),
  .new_status_o   (new_status_o),
  .bank_o         (bank_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic s_rst, s_und, s_svc, s_pabt, s_dabt, s_norm, s_fast;
  logic [AW-1:0] pc;
  logic [31:0]   stat;
  logic          take;
  logic [AW-1:0] vec, lnk;
  logic [4:0]    mode;
  logic [31:0]   sstat, nstat;
  logic [2:0]    bank;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // held expectations
  logic [AW-1:0] e_vec = '0, e_lnk = '0;
  logic [4:0]    e_mode = '0;
  logic [31:0]   e_sstat = '0, e_nstat = '0;
  logic [2:0]    e_bank = '0;
  logic [31:0]   lcg = 32'h1234_5677;

  always #2.5 clk = ~clk;

  exc_entry_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_reset_i(s_rst), .src_undef_i(s_und), .src_svc_i(s_svc),
    .src_pabt_i(s_pabt), .src_dabt_i(s_dabt), .norm_irq_i(s_norm), .fast_irq_i(s_fast),
    .pc_i(pc), .status_i(stat),
    .take_o(take), .vector_o(vec), .mode_o(mode), .link_o(lnk),
    .saved_status_o(sstat), .new_status_o(nstat), .bank_o(bank)
  );

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // src bits: 0 reset,1 undef,2 svc,3 pabt,4 dabt,5 normal irq,6 fast irq
  task automatic drive(logic [6:0] src, logic [AW-1:0] p, logic [31:0] s);
    s_rst = src[0]; s_und = src[1]; s_svc = src[2]; s_pabt = src[3];
    s_dabt = src[4]; s_norm = src[5]; s_fast = src[6];
    pc = p; stat = s;
  endtask

  task automatic run_vec(logic [6:0] src, logic [AW-1:0] p, logic [31:0] s);
    int  k;
    bit  hit;
    logic [4:0] m;
    logic [2:0] b;
    logic [4:0] off;
    bit  fset;
    @(negedge clk);
    drive(src, p, s);
    hit = 1; fset = 0;
    if (src[0])                    begin k = 0; off = 5'h00; m = 5'b10011; b = 3; fset = 1; end
    else if (src[4])               begin k = 1; off = 5'h10; m = 5'b10111; b = 4; end
    else if (src[6] && !s[6])      begin k = 2; off = 5'h1C; m = 5'b10001; b = 1; fset = 1; end
    else if (src[5] && !s[7])      begin k = 3; off = 5'h18; m = 5'b10010; b = 2; end
    else if (src[3])               begin k = 4; off = 5'h0C; m = 5'b10111; b = 4; end
    else if (src[1])               begin k = 5; off = 5'h04; m = 5'b11011; b = 5; end
    else if (src[2])               begin k = 6; off = 5'h08; m = 5'b10011; b = 3; end
    else                           begin k = 7; off = 0; m = 0; b = 0; hit = 0; end
    if (hit) begin
      e_vec   = AW'(off);
      e_mode  = m;
      e_bank  = b;
      e_lnk   = p + AW'(4);
      e_sstat = s;
      e_nstat = {s[31:8], 1'b1, s[6] | fset, 1'b0, m};
    end
    @(negedge clk);
    vectors++;
    cmp("R8 take", 64'(take), 64'(hit));
    cmp("R1/R2 vector", 64'(vec), 64'(e_vec));
    cmp("R3/R4 mode", 64'(mode), 64'(e_mode));
    cmp("R5 link", 64'(lnk), 64'(e_lnk));
    cmp("R5 saved status", 64'(sstat), 64'(e_sstat));
    cmp("R6 new status", 64'(nstat), 64'(e_nstat));
    cmp("R7 bank", 64'(bank), 64'(e_bank));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    drive(7'h7F, 32'hFFFF_FFF0, 32'h0);
    repeat (4) @(negedge clk);
    // R9: reset state with every source active
    vectors++;
    cmp("R9 reset take", 64'(take), 0);
    cmp("R9 reset outputs", 64'(vec | lnk | AW'(mode) | AW'(bank)), 0);
    cmp("R9 reset status", 64'(sstat | nstat), 0);
    drive(7'h0, '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4: full sweep of sources against mask bits and flag patterns
    for (int v = 0; v < 512; v++) begin
      logic [31:0] s;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      s = {lcg[31:28], lcg[27:8], v[7], v[8], v[0], 5'b10000};
      run_vec(v[6:0], lcg, s);
    end

    // R4: level request held high is taken every cycle
    for (int r = 0; r < 3; r++) run_vec(7'b0100000, 32'h100 + 32'(r * 4), 32'hF000_0010);
    // R4: masked held request changes nothing
    for (int r = 0; r < 3; r++) run_vec(7'b1000000, 32'h200, 32'h0000_0050);
    // R5: link wraps at the top of the address range
    run_vec(7'b0001000, 32'hFFFF_FFFC, 32'hA000_0030);
    // R2: undefined beats supervisor call
    run_vec(7'b0000110, 32'h40, 32'h0000_001F);
    // R8: idle cycles hold
    run_vec(7'b0, 32'h0, 32'h0);
    run_vec(7'b0, 32'hDEAD_BEEF, 32'hFFFF_FFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule